// File: doc/BRIEF.md
# Sixteen-bit ALU with shared auxiliary result register

This block is the arithmetic and logic stage of a small word-oriented processor. Each cycle it can accept one operation: an opcode and two unsigned operand words, `lhs` and `rhs`. It computes a primary result word. Some operations also produce a second word, and that word goes into one auxiliary register. The second word is the carry of an addition, the borrow of a subtraction, the high half of a product, or the remainder of a division. The surrounding core reads the auxiliary register back as an ordinary operand in later instructions.

The two compare operations do not return a single flag bit. They return a full mask word: all ones for true and all zeros for false. A later conditional move can therefore test the word directly. Logic, shift and compare operations do not touch the auxiliary register, so a carry or remainder survives until the next arithmetic operation.

Every output is registered. Results appear one clock after the cycle in which `in_valid` is sampled high. A division by a zero divisor returns saturated values and raises `div_zero_err` for that result cycle only.

Top module: `wordalu_top`

## Requirements
- R1: While `rst` is high at a clock edge, `res`, `aux`, `res_valid` and `div_zero_err` all become zero.
- R2: An operation is taken on a clock edge where `in_valid` is high, and its outputs are visible from that edge on with `res_valid` high. When `in_valid` is low at an edge, `res` and `aux` keep their values and `res_valid` goes low.
- R3: ADD (op 0) gives `res` = (lhs + rhs) mod 2^16 and `aux` = the carry out, as 0x0000 or 0x0001.
- R4: SUB (op 1) gives `res` = (lhs − rhs) mod 2^16 and `aux` = 0x0001 when lhs < rhs unsigned (a borrow), otherwise 0x0000.
- R5: MUL (op 2) gives `res` = the low 16 bits and `aux` = the high 16 bits of the unsigned 32-bit product.
- R6: DIV (op 3) with a nonzero divisor gives `res` = the unsigned quotient lhs / rhs and `aux` = the remainder.
- R7: DIV with rhs = 0 gives `res` = 0xFFFF and `aux` = lhs, and `div_zero_err` is high for that one result cycle only.
- R8: AND (op 4) and OR (op 5) are bitwise on lhs and rhs. NOT (op 6) gives the complement of lhs, and rhs has no effect.
- R9: SHL (op 7) and SHR (op 8) shift lhs logically by the amount in rhs, filling with zeros. An amount of 16 or more gives 0x0000.
- R10: EQ (op 9) and GT (op 10, unsigned lhs > rhs) give 0xFFFF when true and 0x0000 when false.
- R11: Ops 4 to 10 and the reserved ops 11 to 15 leave `aux` unchanged. A reserved op gives `res` = 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe; the op is taken at the clock edge |
| op | input | 4 | Operation code |
| lhs | input | 16 | Left operand, dividend, shift source |
| rhs | input | 16 | Right operand, divisor, shift amount |
| res | output | 16 | Registered primary result |
| aux | output | 16 | Auxiliary register: carry, borrow, high product or remainder |
| res_valid | output | 1 | High in the cycle after an accepted operation |
| div_zero_err | output | 1 | One-cycle pulse for a division by zero |

## Verification
Two things can happen in the same cycle. The result register and the auxiliary register can both be written by a single operation, and the error pulse can coincide with a saturated auxiliary write when the divisor is zero. The table drives arithmetic operations that set `aux` next to logic and compare operations that must keep it. Every row therefore judges `res` and `aux` together, with the expected `aux` carried forward from the last arithmetic row. A directed division by zero checks the quotient, the remainder and the error flag in the same result cycle. It then checks that the flag is gone one cycle later.

// File: rtl/wordalu_pkg.sv
package wordalu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_MUL = 4'd2,
    OP_DIV = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_NOT = 4'd6,
    OP_SHL = 4'd7,
    OP_SHR = 4'd8,
    OP_EQ  = 4'd9,
    OP_GT  = 4'd10
  } alu_op_e;
endpackage

// File: rtl/wordalu_arith.sv
module wordalu_arith #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] add_res,
  output logic         add_carry,
  output logic [W-1:0] sub_res,
  output logic         sub_borrow,
  output logic [W-1:0] mul_lo,
  output logic [W-1:0] mul_hi
);
  logic [W:0]     sum_x;
  logic [W:0]     dif_x;
  logic [2*W-1:0] prod;

  always_comb begin
    sum_x = {1'b0, a} + {1'b0, b};
    dif_x = {1'b0, a} - {1'b0, b};
    prod  = a * b;
  end

  assign add_res    = sum_x[W-1:0];
  assign add_carry  = sum_x[W];
  assign sub_res    = dif_x[W-1:0];
  assign sub_borrow = dif_x[W];
  assign mul_lo     = prod[W-1:0];
  assign mul_hi     = prod[2*W-1:W];
endmodule

// File: rtl/wordalu_divider.sv
// Unrolled restoring divider: one compare/subtract step per quotient bit.
// A zero divisor falls out naturally as all-ones quotient, remainder = dividend.
module wordalu_divider #(
  parameter int W = 16
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  logic [W:0]   part;
  logic [W-1:0] q;

  always_comb begin
    part = '0;
    q    = '0;
    for (int i = W - 1; i >= 0; i--) begin
      part = {part[W-1:0], dividend[i]};
      if (part >= {1'b0, divisor}) begin
        part = part - {1'b0, divisor};
        q[i] = 1'b1;
      end
    end
  end

  assign quot = q;
  assign rem  = part[W-1:0];
endmodule

// File: rtl/wordalu_logic.sv
module wordalu_logic #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_res,
  output logic [W-1:0] or_res,
  output logic [W-1:0] not_res,
  output logic [W-1:0] shl_res,
  output logic [W-1:0] shr_res,
  output logic [W-1:0] eq_res,
  output logic [W-1:0] gt_res
);
  localparam int SHW = $clog2(W);
  localparam logic [W-1:0] LIMIT = W[W-1:0];

  logic over;

  assign over    = (b >= LIMIT);
  assign and_res = a & b;
  assign or_res  = a | b;
  assign not_res = ~a;
  assign shl_res = over ? '0 : (a << b[SHW-1:0]);
  assign shr_res = over ? '0 : (a >> b[SHW-1:0]);
  assign eq_res  = (a == b) ? '1 : '0;
  assign gt_res  = (a > b)  ? '1 : '0;
endmodule

// File: rtl/wordalu_top.sv
module wordalu_top
  import wordalu_pkg::*;
#(
  parameter int W  = 16,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [OW-1:0] op,
  input  logic [W-1:0]  lhs,
  input  logic [W-1:0]  rhs,
  output logic [W-1:0]  res,
  output logic [W-1:0]  aux,
  output logic          res_valid,
  output logic          div_zero_err
);
  logic [W-1:0] add_r, sub_r, mul_lo, mul_hi, quot, rem;
  logic         add_c, sub_b;
  logic [W-1:0] and_r, or_r, not_r, shl_r, shr_r, eq_r, gt_r;

  logic [W-1:0] nxt_res, nxt_aux;
  logic         aux_we, dz;

  wordalu_arith #(.W(W)) u_arith (
    .a(lhs), .b(rhs),
    .add_res(add_r), .add_carry(add_c),
    .sub_res(sub_r), .sub_borrow(sub_b),
    .mul_lo(mul_lo), .mul_hi(mul_hi)
  );

  wordalu_divider #(.W(W)) u_div (
    .dividend(lhs), .divisor(rhs), .quot(quot), .rem(rem)
  );

  wordalu_logic #(.W(W)) u_logic (
    .a(lhs), .b(rhs),
    .and_res(and_r), .or_res(or_r), .not_res(not_r),
    .shl_res(shl_r), .shr_res(shr_r), .eq_res(eq_r), .gt_res(gt_r)
  );

  always_comb begin
    nxt_res = '0;
    nxt_aux = aux;
    aux_we  = 1'b0;
    dz      = 1'b0;
    case (alu_op_e'(op[3:0]))
      OP_ADD: begin nxt_res = add_r; nxt_aux = W'(add_c); aux_we = 1'b1; end
      OP_SUB: begin nxt_res = sub_r; nxt_aux = W'(sub_b); aux_we = 1'b1; end
      OP_MUL: begin nxt_res = mul_lo; nxt_aux = mul_hi; aux_we = 1'b1; end
      OP_DIV: begin
        dz      = (rhs == '0);
        nxt_res = dz ? '1 : quot;
        nxt_aux = dz ? lhs : rem;
        aux_we  = 1'b1;
      end
      OP_AND: nxt_res = and_r;
      OP_OR:  nxt_res = or_r;
      OP_NOT: nxt_res = not_r;
      OP_SHL: nxt_res = shl_r;
      OP_SHR: nxt_res = shr_r;
      OP_EQ:  nxt_res = eq_r;
      OP_GT:  nxt_res = gt_r;
      default: nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res          <= '0;
      aux          <= '0;
      res_valid    <= 1'b0;
      div_zero_err <= 1'b0;
    end else begin
      res_valid    <= in_valid;
      div_zero_err <= in_valid & dz;
      if (in_valid) begin
        res <= nxt_res;
        if (aux_we) aux <= nxt_aux;
      end
    end
  end
endmodule

// File: rtl/wordalu_checker.sv
module wordalu_checker
  import wordalu_pkg::*;
#(
  parameter int W  = 16,
  parameter int OW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [OW-1:0] op,
  input logic [W-1:0]  lhs,
  input logic [W-1:0]  rhs,
  input logic [W-1:0]  res,
  input logic [W-1:0]  aux,
  input logic          res_valid,
  input logic          div_zero_err
);
  logic [W:0] sum_ref;
  assign sum_ref = {1'b0, lhs} + {1'b0, rhs};

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && $stable(res) && $stable(aux)));

  assert_add_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_ADD) |=> (aux == W'($past(sum_ref) >> W)));

  assert_div_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_DIV && rhs == '0) |=>
      (div_zero_err && res == '1 && aux == $past(lhs)));

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    div_zero_err |-> res_valid);

  assert_cmp_mask_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_EQ || op == OP_GT)) |=> (res == '1 || res == '0));

  assert_aux_keep_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 4'd4) |=> $stable(aux));
endmodule

bind wordalu_top wordalu_checker #(.W(W), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lhs(lhs), .rhs(rhs),
  .res(res), .aux(aux), .res_valid(res_valid), .div_zero_err(div_zero_err)
);

// File: tb/tb_wordalu_top.sv
module tb_wordalu_top;
  localparam int W = 16;
  localparam int NV = 22;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [3:0]   op;
  logic [W-1:0] lhs, rhs;
  logic [W-1:0] res, aux;
  logic         res_valid, div_zero_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wordalu_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lhs(lhs), .rhs(rhs),
    .res(res), .aux(aux), .res_valid(res_valid), .div_zero_err(div_zero_err)
  );

  // {op, lhs, rhs, expected res, expected aux}; aux carries over on rows that keep it
  localparam logic [67:0] VEC [NV] = '{
    {4'd0,  16'hFFFF, 16'h0001, 16'h0000, 16'h0001},
    {4'd0,  16'h1234, 16'h0001, 16'h1235, 16'h0000},
    {4'd1,  16'h0005, 16'h0007, 16'hFFFE, 16'h0001},
    {4'd1,  16'h0007, 16'h0005, 16'h0002, 16'h0000},
    {4'd2,  16'h1234, 16'h0100, 16'h3400, 16'h0012},
    {4'd4,  16'hF0F0, 16'h3C3C, 16'h3030, 16'h0012},
    {4'd5,  16'hF0F0, 16'h0F00, 16'hFFF0, 16'h0012},
    {4'd6,  16'h00FF, 16'h1234, 16'hFF00, 16'h0012},
    {4'd7,  16'h0001, 16'h000F, 16'h8000, 16'h0012},
    {4'd8,  16'h8000, 16'h0004, 16'h0800, 16'h0012},
    {4'd7,  16'hFFFF, 16'h0010, 16'h0000, 16'h0012},
    {4'd8,  16'hFFFF, 16'h0100, 16'h0000, 16'h0012},
    {4'd9,  16'h5555, 16'h5555, 16'hFFFF, 16'h0012},
    {4'd9,  16'h5555, 16'h5554, 16'h0000, 16'h0012},
    {4'd10, 16'h8000, 16'h7FFF, 16'hFFFF, 16'h0012},
    {4'd10, 16'h7FFF, 16'h8000, 16'h0000, 16'h0012},
    {4'd3,  16'h0064, 16'h0007, 16'h000E, 16'h0002},
    {4'd3,  16'hFFFF, 16'h0001, 16'hFFFF, 16'h0000},
    {4'd2,  16'hFFFF, 16'hFFFF, 16'h0001, 16'hFFFE},
    {4'd12, 16'h1111, 16'h2222, 16'h0000, 16'hFFFE},
    {4'd3,  16'h0003, 16'h0009, 16'h0000, 16'h0003},
    {4'd8,  16'h1234, 16'h0000, 16'h1234, 16'h0003}
  };

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4, 4'd5, 4'd6: return "R8";
      4'd7, 4'd8: return "R9";
      4'd9, 4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
    in_valid = 1'b1; op = o; lhs = a; rhs = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; op = '0; lhs = '0; rhs = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "res", res, '0);
    check("R1", "aux", aux, '0);
    check("R1", "res_valid", W'(res_valid), '0);
    check("R1", "div_zero_err", W'(div_zero_err), '0);

    for (int i = 0; i < NV; i++) begin
      logic [67:0] v;
      v = VEC[i];
      issue(v[67:64], v[63:48], v[47:32]);
      check(req_of(v[67:64]), "res", res, v[31:16]);
      check(req_of(v[67:64]), "aux", aux, v[15:0]);
      check("R2", "res_valid", W'(res_valid), 16'h0001);
      check("R7", "no err", W'(div_zero_err), '0);
    end

    // R2: idle cycle with changed inputs keeps outputs
    in_valid = 1'b0; op = 4'd0; lhs = 16'hAAAA; rhs = 16'h5555;
    @(posedge clk);
    @(negedge clk);
    check("R2", "idle res", res, 16'h1234);
    check("R2", "idle aux", aux, 16'h0003);
    check("R2", "idle valid", W'(res_valid), '0);

    // R7: division by zero, result, remainder and flag in one cycle
    issue(4'd3, 16'h4321, 16'h0000);
    check("R7", "dz res", res, 16'hFFFF);
    check("R7", "dz aux", aux, 16'h4321);
    check("R7", "dz err", W'(div_zero_err), 16'h0001);
    @(posedge clk);
    @(negedge clk);
    check("R7", "err cleared", W'(div_zero_err), '0);

    // R7: back-to-back divide by zero then normal divide
    issue(4'd3, 16'h0009, 16'h0000);
    check("R7", "dz2 err", W'(div_zero_err), 16'h0001);
    issue(4'd3, 16'h0009, 16'h0002);
    check("R6", "div res", res, 16'h0004);
    check("R6", "div aux", aux, 16'h0001);
    check("R7", "err after ok div", W'(div_zero_err), '0);

    // R1: reset mid-run clears state
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", "re-reset res", res, '0);
    check("R1", "re-reset aux", aux, '0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule